// File: doc/BRIEF.md
# Restoring Array Divider

This block divides one unsigned N-bit number by another using only combinational logic. It produces an N-bit quotient and an N-bit remainder, with no clock and no state. The hardware is a grid of identical cells. Each row makes one long-division step: it tries to subtract the divisor from the running partial remainder, and it keeps the difference only when that difference is not negative.

Every cell holds a one-bit full subtractor and a two-way select. The borrow that leaves the top cell of a row tells whether that row's trial went negative. That one signal drives the select of every cell in the row, so each cell passes its own minuend bit straight through and no separate restore step is needed. The inverse of the same borrow is that row's quotient bit. Rows run from the quotient's most significant bit down to its least significant bit. Each row is one bit wider than the divisor, so a partial remainder that briefly needs N+1 bits is still compared correctly.

The block is used wherever a single-cycle unsigned divide is acceptable and its depth of N chained N+1-bit subtractions fits the timing budget.

Top module: `arr_divider`

## Requirements
- R1: For a nonzero divisor, `quot_o` equals the integer quotient floor(dividend / divisor).
- R2: For a nonzero divisor, `rem_o` equals dividend modulo divisor.
- R3: For a nonzero divisor, quot_o * divisor + rem_o equals the dividend, computed at 2N bits.
- R4: For a nonzero divisor, `rem_o` is strictly less than the divisor.
- R5: For a zero divisor, every bit of `quot_o` is 1 and `rem_o` equals the dividend. No error output exists.
- R6: For a divisor of 1, `quot_o` equals the dividend and `rem_o` is 0.
- R7: When the dividend is less than the divisor, `quot_o` is 0 and `rem_o` equals the dividend.
- R8: For a divisor of all ones, `quot_o` is 1 and `rem_o` is 0 when the dividend is also all ones. For any other dividend, `quot_o` is 0 and `rem_o` equals the dividend.
- R9: The outputs are a pure function of the present inputs. They are valid in the same cycle the inputs change, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | N | Unsigned dividend |
| divisor_i | input | N | Unsigned divisor |
| quot_o | output | N | Unsigned quotient, one bit per row, MSB from the first row |
| rem_o | output | N | Remainder from the last row |

## Verification
Each result is due zero cycles after its stimulus, because the block holds no register. The bench applies new operands just after a rising edge of its own timing clock. It reads both outputs at the next falling edge, half a period later, when every ripple has settled and no edge race is possible. The 4-bit instance is checked against the divide and modulo operators over all 256 operand pairs. The 8-bit instance is driven with directed divisors 0, 1 and all ones, dividends below the divisor, and random pairs.

// File: rtl/arr_divider_pkg.sv
package arr_divider_pkg;

  // Result of one divider cell: the selected bit and the borrow it hands upward.
  typedef struct packed {
    logic bit_o;
    logic borrow;
  } cell_res_t;

  // One-bit subtract: minuend x, subtrahend y, incoming borrow b.
  function automatic cell_res_t sub_bit(input logic x, input logic y, input logic b);
    cell_res_t r;
    r.bit_o  = x ^ y ^ b;
    r.borrow = (~x & y) | (~(x ^ y) & b);
    return r;
  endfunction

endpackage

// File: rtl/arr_divider_cell.sv
module arr_divider_cell
  import arr_divider_pkg::*;
(
  input  logic min_i,
  input  logic sub_i,
  input  logic bin_i,
  input  logic keep_i,
  output logic out_o,
  output logic bout_o
);

  cell_res_t res;

  always_comb begin
    res    = sub_bit(min_i, sub_i, bin_i);
    // keep_i asserted: trial failed, pass the minuend bit (subtract zero)
    out_o  = keep_i ? min_i : res.bit_o;
    bout_o = res.borrow;
  end

endmodule

// File: rtl/arr_divider_row.sv
module arr_divider_row #(
  parameter int N = 8
) (
  input  logic [N:0] minuend_i,
  input  logic [N-1:0] divisor_i,
  output logic [N:0] result_o,
  output logic qbit_o
);

  localparam int W = N + 1;

  logic [W-1:0] subtrahend;
  logic [W:0]   borrow_chain;
  logic         keep;

  assign subtrahend      = {1'b0, divisor_i};
  assign borrow_chain[0] = 1'b0;
  // Borrow out of the top cell means the trial difference went negative.
  assign keep            = borrow_chain[W];
  assign qbit_o          = ~keep;

  for (genvar c = 0; c < W; c++) begin : g_cell
    arr_divider_cell u_cell (
      .min_i  (minuend_i[c]),
      .sub_i  (subtrahend[c]),
      .bin_i  (borrow_chain[c]),
      .keep_i (keep),
      .out_o  (result_o[c]),
      .bout_o (borrow_chain[c+1])
    );
  end

endmodule

// File: rtl/arr_divider.sv
module arr_divider #(
  parameter int N = 8
) (
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic [N-1:0] quot_o,
  output logic [N-1:0] rem_o
);

  localparam int W = N + 1;

  // part[k] is the partial remainder entering row k; part[N] is the final one.
  logic [N-1:0] part [N+1];
  logic [W-1:0] row_out [N];

  assign part[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_row
    logic [W-1:0] minuend;
    // Shift in the next dividend bit, most significant first.
    assign minuend = {part[k], dividend_i[N-1-k]};

    arr_divider_row #(.N(N)) u_row (
      .minuend_i (minuend),
      .divisor_i (divisor_i),
      .result_o  (row_out[k]),
      .qbit_o    (quot_o[N-1-k])
    );

    // A kept or successful result always fits in N bits.
    assign part[k+1] = row_out[k][N-1:0];
  end

  assign rem_o = part[N];

endmodule

// File: rtl/arr_divider_chk.sv
module arr_divider_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] dividend_i,
  input logic [N-1:0] divisor_i,
  input logic [N-1:0] quot_o,
  input logic [N-1:0] rem_o
);

  localparam int W2 = 2 * N;

  logic [W2-1:0] recon;
  assign recon = W2'(quot_o) * W2'(divisor_i) + W2'(rem_o);

  always_comb begin
    if (divisor_i != '0) begin
      a_r3_identity: assert (recon == W2'(dividend_i))
        else $error("R3 identity broken");
      a_r4_rem_below_div: assert (rem_o < divisor_i)
        else $error("R4 remainder not below divisor");
    end
    if (divisor_i == '0) begin
      a_r5_zero_div: assert (quot_o == '1 && rem_o == dividend_i)
        else $error("R5 zero divisor result wrong");
    end
    if (divisor_i == N'(1)) begin
      a_r6_unit_div: assert (quot_o == dividend_i && rem_o == '0)
        else $error("R6 unit divisor result wrong");
    end
    if (dividend_i < divisor_i) begin
      a_r7_small_dividend: assert (quot_o == '0 && rem_o == dividend_i)
        else $error("R7 small dividend result wrong");
    end
  end

endmodule

bind arr_divider arr_divider_chk #(.N(N)) u_chk (
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quot_o     (quot_o),
  .rem_o      (rem_o)
);

// File: tb/sim_arr_divider.sv
module sim_arr_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk;
  logic rst_n;
  int   n_checks;
  int   n_fail;
  bit   done;

  logic [7:0] a8, d8, q8, r8;
  logic [3:0] a4, d4, q4, r4;

  arr_divider #(.N(8)) u0 (.dividend_i(a8), .divisor_i(d8), .quot_o(q8), .rem_o(r8));
  arr_divider #(.N(4)) u1 (.dividend_i(a4), .divisor_i(d4), .quot_o(q4), .rem_o(r4));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Drive after a rising edge, sample at the falling edge (zero-cycle latency).
  task automatic apply8(input int a, input int d);
    @(posedge clk);
    a8 = 8'(a);
    d8 = 8'(d);
    @(negedge clk);
  endtask

  task automatic t_idle;
    // Operands held at zero after reset: divide by zero gives all ones, remainder 0.
    @(negedge clk);
    chk("R5", "idle quotient", int'(q8), 255);
    chk("R5", "idle remainder", int'(r8), 0);
  endtask

  task automatic t_exhaustive4;
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 16; d++) begin
        @(posedge clk);
        a4 = 4'(a);
        d4 = 4'(d);
        @(negedge clk);
        if (d == 0) begin
          chk("R5", "n4 quotient", int'(q4), 15);
          chk("R5", "n4 remainder", int'(r4), a);
        end else begin
          chk("R1", "n4 quotient", int'(q4), a / d);
          chk("R2", "n4 remainder", int'(r4), a % d);
        end
      end
    end
  endtask

  task automatic t_zero_div;
    int vals[4] = '{0, 1, 128, 255};
    foreach (vals[i]) begin
      apply8(vals[i], 0);
      chk("R5", "zero divisor quotient", int'(q8), 255);
      chk("R5", "zero divisor remainder", int'(r8), vals[i]);
    end
  endtask

  task automatic t_unit_div;
    int vals[4] = '{0, 1, 170, 255};
    foreach (vals[i]) begin
      apply8(vals[i], 1);
      chk("R6", "unit divisor quotient", int'(q8), vals[i]);
      chk("R6", "unit divisor remainder", int'(r8), 0);
    end
  endtask

  task automatic t_ones_div;
    int vals[4] = '{0, 1, 254, 255};
    foreach (vals[i]) begin
      apply8(vals[i], 255);
      chk("R8", "ones divisor quotient", int'(q8), (vals[i] == 255) ? 1 : 0);
      chk("R8", "ones divisor remainder", int'(r8), (vals[i] == 255) ? 0 : vals[i]);
    end
  endtask

  task automatic t_small;
    int pa[4] = '{0, 5, 99, 254};
    int pd[4] = '{3, 6, 200, 255};
    foreach (pa[i]) begin
      apply8(pa[i], pd[i]);
      chk("R7", "small dividend quotient", int'(q8), 0);
      chk("R7", "small dividend remainder", int'(r8), pa[i]);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      int a;
      int d;
      a = int'($urandom_range(255, 0));
      d = int'($urandom_range(255, 1));
      apply8(a, d);
      chk("R1", "random quotient", int'(q8), a / d);
      chk("R2", "random remainder", int'(r8), a % d);
      chk("R3", "random reconstruction", int'(q8) * d + int'(r8), a);
      chk("R4", "random remainder below divisor", (int'(r8) < d) ? 1 : 0, 1);
    end
  endtask

  task automatic t_same_cycle;
    // R9: a new operand pair is reflected within half a clock, no stored state.
    apply8(200, 7);
    chk("R9", "first pair quotient", int'(q8), 28);
    apply8(13, 13);
    chk("R9", "next pair quotient", int'(q8), 1);
    chk("R9", "next pair remainder", int'(r8), 0);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a8 = '0; d8 = '0; a4 = '0; d4 = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_exhaustive4();
    t_zero_div();
    t_unit_div();
    t_ones_div();
    t_small();
    t_same_cycle();
    t_random();
    finish_run();
  end

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule